// File: doc/BRIEF.md
# Half-Duplex Buffered Serial Flash Master

This block is a register-mapped serial master aimed at flash-style traffic. A transfer is a strict sequence of up to three phases: command bits taken from a 32-bit command word, then outgoing data bits taken from a bank of eight 32-bit data words, then incoming bits captured back into that same bank. Software loads the command and data words and writes the three bit counts into one packed count register. It then sets a start bit and polls a busy flag until the transfer is over.

The serial clock is the system clock divided by a programmable ratio. Only clock mode 0 is produced: SCK idles low, the slave's data is sampled on the rising edge, and MOSI moves on the falling edge. Bit order within each byte is selectable. Two chip selects are driven directly from a register, so software can hold a device selected across several transfers.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, every spi_cs_n line is high, spi_sck and spi_mosi are low, and busy (bit 16 of offset 0x00) reads 0.
- R2: Writing a 1 to bit 8 of offset 0x00 while idle with at least one nonzero count starts a transfer. Busy reads 1 from the next cycle and clears exactly one system clock after the last SCK falling edge, so it stays high for T*N+1 cycles, where T is the total number of bits and N is the divide ratio. If all three counts are zero, the start does nothing and busy stays 0.
- R3: The SCK period is N = clk_sel+2 system clocks, where clk_sel is config bits [27:16]. Each period has ceil(N/2) clocks low followed by floor(N/2) clocks high, and the first rising edge comes ceil(N/2) clocks after the start edge. SCK is low whenever the block is idle.
- R4: The count register at 0x2C holds the command count in bits [29:24], the receive count in bits [20:12] and the transmit count in bits [8:0]. A command count above 32 acts as 32, and the other two counts are capped at 256. The phases run command, then transmit, then receive. A phase with a zero count is skipped, so the number of SCK pulses equals the sum of the effective counts.
- R5: Command bits come from the word at 0x04. Command byte k sits in bits [31-8k:24-8k], so the first byte sent is the most significant byte.
- R6: Transmit byte k comes from the data word at offset 0x08+4*(k/4), bits [8*(k%4)+7 : 8*(k%4)].
- R7: Receive bit n is taken from spi_miso on SCK rising edge number n of the receive phase. It is stored in the data bank using the same byte layout as R6 and the same bit order as R8. Bits that are not received keep their previous value.
- R8: Config bit 3 selects bit order. At 0, each byte goes most significant bit first. At 1, each byte goes least significant bit first. The setting applies to all three phases.
- R9: A start written while a transfer is running is ignored. The running transfer keeps its pulse count and its busy timing.
- R10: Bit n of offset 0x38 drives spi_cs_n[n]: a 1 makes the line low and a 0 makes it high. The lines hold their value through and between transfers until software rewrites the register.
- R11: MOSI changes only while SCK is low. It is 0 during the receive phase and while idle.
- R12: Config at 0x28 reads back bits [31:29], [27:16] and bits 5 to 2 as written. Bit 10 (full-duplex request) and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
A start write sampled at edge S shows busy after that same edge. SCK rises for the first time at edge S+ceil(N/2) and then once every N edges. The last falling edge is S+T*N, and busy drops at S+T*N+1. The bench drives inputs and samples outputs on falling clock edges. It reads busy exactly T*N and T*N+1 falling edges after the start write, and it compares SCK rise times against the start edge time. MOSI is captured on each SCK rise, and the slave model changes MISO just after each rise, so each bit is exchanged in the cycle where the design samples it. Captured data is read back only after busy has cleared.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int unsigned CMD_CNT_W = 6;
    localparam int unsigned DAT_CNT_W = 9;
    localparam int unsigned CMD_MAX   = 32;

    localparam logic [5:0] ADR_CTRL  = 6'h00;
    localparam logic [5:0] ADR_CMD   = 6'h04;
    localparam logic [5:0] ADR_DATA0 = 6'h08;
    localparam logic [5:0] ADR_CFG   = 6'h28;
    localparam logic [5:0] ADR_CNT   = 6'h2C;
    localparam logic [5:0] ADR_SEL   = 6'h38;

    localparam int unsigned START_BIT = 8;
    localparam int unsigned BUSY_BIT  = 16;
    localparam logic [31:0] CFG_KEEP  = 32'hEFFF_003C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TX,
        ST_RX,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [CMD_CNT_W-1:0] cmd;
        logic [DAT_CNT_W-1:0] tx;
        logic [DAT_CNT_W-1:0] rx;
    } phase_len_t;

    function automatic logic [2:0] bit_in_byte(input logic [2:0] k, input logic lsb_first);
        return lsb_first ? k : ~k;
    endfunction

    function automatic seq_state_e next_phase(input seq_state_e cur, input phase_len_t len);
        seq_state_e nxt;
        nxt = ST_TAIL;
        case (cur)
            ST_IDLE: begin
                if (len.cmd != '0)     nxt = ST_CMD;
                else if (len.tx != '0) nxt = ST_TX;
                else if (len.rx != '0) nxt = ST_RX;
            end
            ST_CMD: begin
                if (len.tx != '0)      nxt = ST_TX;
                else if (len.rx != '0) nxt = ST_RX;
            end
            ST_TX: begin
                if (len.rx != '0)      nxt = ST_RX;
            end
            default: nxt = ST_TAIL;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/spi_fm_sckgen.sv
module spi_fm_sckgen #(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             sck,
    output logic             rise_p,
    output logic             fall_p
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] ratio, hi_len, lo_len, cnt;

    assign ratio  = {1'b0, div_sel} + CW'(2);
    assign hi_len = ratio >> 1;
    assign lo_len = ratio - hi_len;

    assign rise_p = run && !sck && (cnt == lo_len - CW'(1));
    assign fall_p = run &&  sck && (cnt == hi_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sck <= 1'b0;
            cnt <= '0;
        end else if (rise_p) begin
            sck <= 1'b1;
            cnt <= '0;
        end else if (fall_p) begin
            sck <= 1'b0;
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/spi_fm_seq.sv
module spi_fm_seq
    import spi_fm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  phase_len_t           len_in,
    input  logic                 rise_p,
    input  logic                 fall_p,
    output seq_state_e           state,
    output logic [DAT_CNT_W-1:0] ofs,
    output logic                 busy,
    output logic                 run,
    output logic                 cap_we
);
    phase_len_t           len_q;
    logic [DAT_CNT_W-1:0] cur_len;
    logic                 start_ok;

    assign start_ok = start && (state == ST_IDLE) && (len_in != '0);
    assign run      = (state == ST_CMD) || (state == ST_TX) || (state == ST_RX);
    assign busy     = (state != ST_IDLE);
    assign cap_we   = rise_p && (state == ST_RX);

    always_comb begin
        case (state)
            ST_CMD:  cur_len = DAT_CNT_W'(len_q.cmd);
            ST_TX:   cur_len = len_q.tx;
            ST_RX:   cur_len = len_q.rx;
            default: cur_len = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ofs   <= '0;
            len_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state <= next_phase(ST_IDLE, len_in);
                        len_q <= len_in;
                        ofs   <= '0;
                    end
                end
                ST_TAIL: state <= ST_IDLE;
                default: begin
                    if (fall_p) begin
                        if (ofs == cur_len - DAT_CNT_W'(1)) begin
                            state <= next_phase(state, len_q);
                            ofs   <= '0;
                        end else begin
                            ofs <= ofs + DAT_CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R9: a start arriving mid-transfer must not relatch the counts
    p_len_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(len_q));

endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spi_fm_pkg::*;
#(
    parameter int unsigned DATA_WORDS = 8,
    parameter int unsigned CS_COUNT   = 2,
    parameter int unsigned DIV_W      = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [5:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                spi_sck,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [CS_COUNT-1:0] spi_cs_n
);
    localparam int unsigned DATA_BITS = DATA_WORDS * 32;
    localparam int unsigned DBIT_W    = $clog2(DATA_BITS);
    localparam int unsigned WIDX_W    = $clog2(DATA_WORDS);
    localparam int unsigned DATA_END  = 8 + 4 * DATA_WORDS;

    logic [31:0]            cmd_q;
    logic [DATA_BITS-1:0]   data_q;
    logic [31:0]            cfg_q;
    phase_len_t             cnt_q;
    logic [CS_COUNT-1:0]    sel_q;

    logic                   in_data;
    logic [5:0]             data_ofs;
    logic [WIDX_W-1:0]      widx;
    logic                   start_wr;
    phase_len_t             len_eff;

    seq_state_e             state;
    logic [DAT_CNT_W-1:0]   ofs;
    logic                   busy, run, cap_we, rise_p, fall_p;
    logic [2:0]             bpos;
    logic [DBIT_W-1:0]      buf_idx;

    assign in_data  = (int'(reg_addr) >= 8) && (int'(reg_addr) < DATA_END);
    assign data_ofs = reg_addr - ADR_DATA0;
    assign widx     = data_ofs[2 +: WIDX_W];
    assign start_wr = reg_we && (reg_addr == ADR_CTRL) && reg_wdata[START_BIT];

    always_comb begin
        len_eff.cmd = (cnt_q.cmd > CMD_CNT_W'(CMD_MAX)) ? CMD_CNT_W'(CMD_MAX) : cnt_q.cmd;
        len_eff.tx  = (cnt_q.tx  > DAT_CNT_W'(DATA_BITS)) ? DAT_CNT_W'(DATA_BITS) : cnt_q.tx;
        len_eff.rx  = (cnt_q.rx  > DAT_CNT_W'(DATA_BITS)) ? DAT_CNT_W'(DATA_BITS) : cnt_q.rx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cfg_q <= '0;
            cnt_q <= '0;
            sel_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADR_CMD: cmd_q <= reg_wdata;
                ADR_CFG: cfg_q <= reg_wdata & CFG_KEEP;
                ADR_CNT: begin
                    cnt_q.cmd <= reg_wdata[24 +: CMD_CNT_W];
                    cnt_q.rx  <= reg_wdata[12 +: DAT_CNT_W];
                    cnt_q.tx  <= reg_wdata[0  +: DAT_CNT_W];
                end
                ADR_SEL: sel_q <= reg_wdata[CS_COUNT-1:0];
                default: ;
            endcase
        end
    end

    assign bpos    = bit_in_byte(ofs[2:0], cfg_q[3]);
    assign buf_idx = {ofs[DBIT_W-1:3], bpos};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            if (reg_we && in_data) data_q[widx*32 +: 32] <= reg_wdata;
            if (cap_we)            data_q[buf_idx]       <= spi_miso;
        end
    end

    spi_fm_sckgen #(.DIV_W(DIV_W)) u_sck (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_sel (cfg_q[16 +: DIV_W]),
        .sck     (spi_sck),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    spi_fm_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_wr),
        .len_in (len_eff),
        .rise_p (rise_p),
        .fall_p (fall_p),
        .state  (state),
        .ofs    (ofs),
        .busy   (busy),
        .run    (run),
        .cap_we (cap_we)
    );

    always_comb begin
        case (state)
            ST_CMD:  spi_mosi = cmd_q[{~ofs[4:3], bpos}];
            ST_TX:   spi_mosi = data_q[buf_idx];
            default: spi_mosi = 1'b0;
        endcase
    end

    always_comb begin
        reg_rdata = '0;
        if (in_data) begin
            reg_rdata = data_q[widx*32 +: 32];
        end else begin
            case (reg_addr)
                ADR_CTRL: reg_rdata[BUSY_BIT] = busy;
                ADR_CMD:  reg_rdata = cmd_q;
                ADR_CFG:  reg_rdata = cfg_q;
                ADR_CNT: begin
                    reg_rdata[24 +: CMD_CNT_W] = cnt_q.cmd;
                    reg_rdata[12 +: DAT_CNT_W] = cnt_q.rx;
                    reg_rdata[0  +: DAT_CNT_W] = cnt_q.tx;
                end
                ADR_SEL:  reg_rdata[CS_COUNT-1:0] = sel_q;
                default:  reg_rdata = '0;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < CS_COUNT; g++) begin : g_cs
            assign spi_cs_n[g] = ~sel_q[g];
        end
    endgenerate

    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sck);

    p_busy_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!$past(spi_sck) && $past(spi_sck, 2)));

    p_mosi_quiet_high_r11: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck) && !$past(reg_we)) |-> $stable(spi_mosi));

    p_mosi_zero_rx_r11: assert property (@(posedge clk) disable iff (rst)
        cap_we |-> !spi_mosi);

endmodule

// File: tb/tb_spi_flash_master.sv
module tb_spi_flash_master;

    typedef struct packed {
        logic [11:0] sel;
        logic        lsb;
        logic [5:0]  c;
        logic [8:0]  m;
        logic [8:0]  r;
        logic [31:0] cmd;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{12'd0, 1'b0, 6'd8,  9'd0,   9'd16,  32'h03AA55CC, 8'd1},
        '{12'd1, 1'b0, 6'd32, 9'd24,  9'd0,   32'h0B123456, 8'd2},
        '{12'd3, 1'b1, 6'd8,  9'd16,  9'd8,   32'hC3000000, 8'd3},
        '{12'd0, 1'b0, 6'd0,  9'd0,   9'd256, 32'h00000000, 8'd4},
        '{12'd2, 1'b1, 6'd40, 9'd9,   9'd11,  32'h9ABCDEF0, 8'd5},
        '{12'd0, 1'b0, 6'd0,  9'd256, 9'd0,   32'h00000000, 8'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    int total = 0;
    int bad   = 0;
    int rise_cnt = 0;
    logic cap_bit [2048];
    longint rise_t [2048];
    longint t_start;
    logic [255:0] mdata;

    always #2 clk = ~clk;

    spi_flash_master dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    function automatic logic miso_fn(input int k);
        int h;
        h = (k * 29 + 7) ^ (k >> 2);
        return h[3];
    endfunction

    assign spi_miso = miso_fn(rise_cnt);

    always @(posedge spi_sck) begin
        if (rise_cnt < 2048) begin
            cap_bit[rise_cnt] = spi_mosi;
            rise_t[rise_cnt]  = $time;
        end
        rise_cnt = rise_cnt + 1;
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        t_start = $time;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [2:0] bib(input int k, input logic lsb);
        logic [2:0] b;
        b = 3'(k % 8);
        return lsb ? b : 3'(7 - k % 8);
    endfunction

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(spi_cs_n == 2'b11, "R1 cs_n", spi_cs_n, 2'b11);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi", {spi_sck, spi_mosi}, 0);
        rd(6'h00, d);
        chk(d[16] == 1'b0, "R1 busy", d[16], 0);

        // R12 config readback
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h28, d);
        chk(d == 32'hEFFF_003C, "R12 cfg readback", d, 32'hEFFF_003C);

        // main vector table
        for (int v = 0; v < NV; v++) begin
            vec_t cv;
            int ce, me, re, n_div, lo, tt, errs, first_bad;
            logic expb;
            cv = VEC[v];
            ce = (cv.c > 32) ? 32 : int'(cv.c);
            me = (cv.m > 256) ? 256 : int'(cv.m);
            re = (cv.r > 256) ? 256 : int'(cv.r);
            n_div = int'(cv.sel) + 2;
            lo = n_div - n_div / 2;
            tt = ce + me + re;

            wr(6'h28, {4'b0, cv.sel, 12'h000, cv.lsb, 3'b100});
            wr(6'h04, cv.cmd);
            for (int w = 0; w < 8; w++) begin
                logic [31:0] word;
                word = (32'(cv.seed) * 32'h9E37_79B9) ^ (32'(w) * 32'h0101_0111);
                mdata[w*32 +: 32] = word;
                wr(6'(8 + 4 * w), word);
            end
            wr(6'h2C, {2'b0, cv.c, 3'b0, cv.r, 3'b0, cv.m});
            base = rise_cnt;
            wr(6'h00, 32'h0000_0100);

            // R2 busy window
            repeat (tt * n_div) @(negedge clk);
            chk(reg_rdata[16] == 1'b1, "R2 busy still high", reg_rdata[16], 1);
            @(negedge clk);
            chk(reg_rdata[16] == 1'b0, "R2 busy cleared", reg_rdata[16], 0);

            // R4 pulse count and order
            chk(rise_cnt - base == tt, "R4 sck pulses", rise_cnt - base, tt);

            // R5 R6 R8 R11 mosi stream
            errs = 0; first_bad = -1;
            for (int i = 0; i < tt; i++) begin
                if (i < ce) expb = cv.cmd[(3 - i / 8) * 8 + int'(bib(i, cv.lsb))];
                else if (i < ce + me) expb = mdata[((i - ce) / 8) * 8 + int'(bib(i - ce, cv.lsb))];
                else expb = 1'b0;
                if (cap_bit[base + i] !== expb) begin
                    errs++;
                    if (first_bad < 0) first_bad = i;
                end
            end
            chk(errs == 0, "R5 R6 R8 R11 mosi stream", first_bad, -1);

            // R3 clock timing
            chk(rise_t[base] - t_start == longint'(lo * 4), "R3 first rise",
                rise_t[base] - t_start, lo * 4);
            if (tt >= 2)
                chk(rise_t[base + 1] - rise_t[base] == longint'(n_div * 4), "R3 period",
                    rise_t[base + 1] - rise_t[base], n_div * 4);

            // R7 receive capture
            for (int n = 0; n < re; n++)
                mdata[(n / 8) * 8 + int'(bib(n, cv.lsb))] = miso_fn(base + ce + me + n);
            for (int w = 0; w < 8; w++) begin
                rd(6'(8 + 4 * w), d);
                chk(d == mdata[w*32 +: 32], "R7 data word", d, mdata[w*32 +: 32]);
            end
            chk(spi_mosi == 1'b0 && spi_sck == 1'b0, "R11 idle lines", {spi_sck, spi_mosi}, 0);
        end

        // R10 chip select held across a transfer, R9 start while busy
        wr(6'h38, 32'h1);
        chk(spi_cs_n == 2'b10, "R10 cs0 low", spi_cs_n, 2'b10);
        wr(6'h28, 32'h0);
        wr(6'h04, 32'hA500_0000);
        wr(6'h2C, {2'b0, 6'd8, 24'h0});
        base = rise_cnt;
        wr(6'h00, 32'h0000_0100);
        repeat (3) @(negedge clk);
        wr(6'h00, 32'h0000_0100);
        reg_addr = 6'h00;
        repeat (11) @(negedge clk);
        chk(reg_rdata[16] == 1'b1, "R9 busy timing kept", reg_rdata[16], 1);
        @(negedge clk);
        chk(reg_rdata[16] == 1'b0, "R9 busy clears on time", reg_rdata[16], 0);
        repeat (4) @(negedge clk);
        chk(rise_cnt - base == 8, "R9 no restart", rise_cnt - base, 8);
        chk(spi_cs_n == 2'b10, "R10 cs held after transfer", spi_cs_n, 2'b10);
        wr(6'h38, 32'h2);
        chk(spi_cs_n == 2'b01, "R10 cs1 low", spi_cs_n, 2'b01);
        wr(6'h38, 32'h0);
        chk(spi_cs_n == 2'b11, "R10 cs released", spi_cs_n, 2'b11);

        // R2 zero counts: start does nothing
        wr(6'h2C, 32'h0);
        base = rise_cnt;
        wr(6'h00, 32'h0000_0100);
        chk(reg_rdata[16] == 1'b0, "R2 zero-count start", reg_rdata[16], 0);
        repeat (6) @(negedge clk);
        chk(rise_cnt == base, "R2 zero-count no pulses", rise_cnt - base, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule